// File: doc/BRIEF.md
# SPI Serial Clock Divider Solver and Generator

This block converts a requested serial bit rate into the two divider fields of a cascaded clock generator, then uses them to make the serial clock. The request is a single integer: the number of main-clock cycles in one serial-clock period. The generator has two stages. A power-of-two prescaler divides the main clock by `2 << div_o`. A linear stage then divides that result by `2 * (brg_o + 1)`. The serial period is therefore `(2 << div_o) * 2 * (brg_o + 1)` main cycles. `brg_o` is legal only from 4 to 63, and `div_o` only from 0 to 3.

A one-cycle `start` strobe captures the ratio. The solver then tries each prescaler setting in rising order, one setting per cycle. It keeps the first setting whose linear quotient fits. When the request is too fast or too slow, it clamps to the nearest end of the legal range. The block also reports the smallest and largest period ratios it can reach. The clock generator holds the serial clock at a selectable idle level while it is disabled. It picks up the solver's latest result only while disabled, so a running clock never changes rate partway through a transfer.

Top module: `spi_rate_gen`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, `div_o` is 0 and `brg_o` is 4. Once reset is released with `sclk_en` low, `sclk` equals `sclk_idle`.
- R2: After a start is accepted, the solver evaluates candidates `div` = 0, 1, 2, 3 in that order, one per clock. `done` rises in the cycle after the edge that evaluates the chosen candidate. The latency is therefore `div_o`+1 cycles after the start edge, or 4 cycles when the slow clamp applies.
- R3: For a candidate, let q = floor(ratio / (4 << div)). The result is the first candidate with 5 <= q <= 64. It gives that `div` and `brg_o` = q-1.
- R4: If q at candidate 0 is below 5 (ratio < 20), the result is `div_o`=0 and `brg_o`=4, with latency 1.
- R5: If no candidate fits (ratio >= 2080), the result is `div_o`=3 and `brg_o`=63, with latency 4.
- R6: A start with ratio 0 raises `err` for exactly one cycle after the start edge. It produces no `done`, and `div_o`/`brg_o` keep their previous values.
- R7: A `start` while `busy` is high is ignored. The running search finishes with the first ratio, and no second result follows.
- R8: `min_ratio` reads 20 and `max_ratio` reads 2048. These are the fastest and slowest reachable serial periods, in main cycles.
- R9: While `sclk_en` is low, `sclk` is driven to `sclk_idle` one cycle later.
- R10: While enabled, `sclk` toggles every `(2 << div) * (brg + 1)` cycles. The first toggle comes that many cycles after `sclk_en` rises.
- R11: A result produced while `sclk_en` is high does not change the running rate. It takes effect only after the generator has been disabled.
- R12: `done` is a single-cycle pulse. `busy` is high from the cycle after the start edge until `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe that begins a search with `ratio` |
| ratio | input | RATIO_W | Requested main-to-serial period ratio |
| sclk_en | input | 1 | Enables the serial clock generator |
| sclk_idle | input | 1 | Level of `sclk` while disabled |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: new `div_o`/`brg_o` valid |
| err | output | 1 | One-cycle pulse: request ratio was zero |
| div_o | output | 2 | Chosen prescaler exponent |
| brg_o | output | 6 | Chosen linear divider field |
| min_ratio | output | RATIO_W | Smallest reachable period ratio |
| max_ratio | output | RATIO_W | Largest reachable period ratio |
| sclk | output | 1 | Serial clock |

## Verification
The solver is driven with ratios that stop the search at each candidate. Ratio 100 stops at candidate 0, 260 at candidate 1, 1000 at candidate 2 and 2079 at candidate 3. This separates a correct in-order search from one that skips or reorders settings, and it checks the latency of each stop. Edge ratios come next. Ratios 1, 19 and 20 tell the fast clamp from an exact minimum, and 259 versus 260 shows the boundary between two candidates. Ratios 2080 and 65535 show the slow clamp against the last legal fit. Zero and mid-search restarts test the reject and ignore paths. The generator is timed at three rates to check half-period length. It is also timed across a solver result that arrives while running, which tells apart a generator that reloads only while idle from one that reloads at once.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  localparam int DIV_W   = 2;
  localparam int BRG_W   = 6;
  localparam int BRG_LO  = 4;
  localparam int BRG_HI  = 63;
  localparam int DIV_HI  = (1 << DIV_W) - 1;
  localparam int PRE_W   = DIV_HI + 2;
  localparam int MIN_RATIO = (2 << 0) * 2 * (BRG_LO + 1);
  localparam int MAX_RATIO = (2 << DIV_HI) * 2 * (BRG_HI + 1);

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [BRG_W-1:0] brg;
  } rate_cfg_t;

  localparam rate_cfg_t CFG_FASTEST = '{div: '0, brg: BRG_W'(BRG_LO)};
  localparam rate_cfg_t CFG_SLOWEST = '{div: DIV_W'(DIV_HI), brg: BRG_W'(BRG_HI)};
endpackage

// File: rtl/spi_rate_cand.sv
module spi_rate_cand
  import spi_rate_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic [RATIO_W-1:0] ratio,
  input  logic [DIV_W-1:0]   div,
  output logic               too_fast,
  output logic               fits,
  output logic [BRG_W-1:0]   brg
);
  logic [DIV_W:0]   shamt;
  logic [RATIO_W-1:0] quot;

  // quotient is BRG+1 for this prescaler candidate
  assign shamt    = {1'b0, div} + (DIV_W+1)'(2);
  assign quot     = ratio >> shamt;
  assign too_fast = quot < RATIO_W'(BRG_LO + 1);
  assign fits     = quot <= RATIO_W'(BRG_HI + 1);
  assign brg      = BRG_W'(quot - RATIO_W'(1));
endmodule

// File: rtl/spi_rate_solver.sv
module spi_rate_solver
  import spi_rate_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               start,
  input  logic [RATIO_W-1:0] ratio,
  output logic               busy,
  output logic               done,
  output logic               err,
  output rate_cfg_t          result
);
  typedef enum logic {S_IDLE, S_SEARCH} state_t;

  state_t             state_q, state_d;
  logic [DIV_W-1:0]   idx_q, idx_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  rate_cfg_t          res_q, res_d;
  logic               done_q, done_d;
  logic               err_q, err_d;

  logic               c_fast, c_fits;
  logic [BRG_W-1:0]   c_brg;

  spi_rate_cand #(.RATIO_W(RATIO_W)) i_cand (
    .ratio    (ratio_q),
    .div      (idx_q),
    .too_fast (c_fast),
    .fits     (c_fits),
    .brg      (c_brg)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ratio_d = ratio_q;
    res_d   = res_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          if (ratio == '0) begin
            err_d = 1'b1;
          end else begin
            state_d = S_SEARCH;
            ratio_d = ratio;
            idx_d   = '0;
          end
        end
      end
      S_SEARCH: begin
        if (c_fast) begin
          res_d   = '{div: idx_q, brg: BRG_W'(BRG_LO)};
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else if (c_fits) begin
          res_d   = '{div: idx_q, brg: c_brg};
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else if (idx_q == DIV_W'(DIV_HI)) begin
          res_d   = CFG_SLOWEST;
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          idx_d = idx_q + DIV_W'(1);
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      ratio_q <= '0;
      res_q   <= CFG_FASTEST;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ratio_q <= ratio_d;
      res_q   <= res_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy   = (state_q == S_SEARCH);
  assign done   = done_q;
  assign err    = err_q;
  assign result = res_q;
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_rate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      en,
  input  logic      idle_lvl,
  input  rate_cfg_t cfg_in,
  output rate_cfg_t act_cfg,
  output logic      sclk
);
  rate_cfg_t        act_q, act_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [BRG_W-1:0] lin_q, lin_d;
  logic             sclk_q, sclk_d;
  logic [PRE_W-1:0] pre_last;

  assign pre_last = (PRE_W'(2) << act_q.div) - PRE_W'(1);

  always_comb begin
    act_d  = act_q;
    pre_d  = pre_q;
    lin_d  = lin_q;
    sclk_d = sclk_q;
    if (!en) begin
      act_d  = cfg_in;
      pre_d  = '0;
      lin_d  = '0;
      sclk_d = idle_lvl;
    end else begin
      pre_d = pre_q + PRE_W'(1);
      if (pre_q == pre_last) begin
        pre_d = '0;
        if (lin_q == act_q.brg) begin
          lin_d  = '0;
          sclk_d = ~sclk_q;
        end else begin
          lin_d = lin_q + BRG_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= CFG_FASTEST;
      pre_q  <= '0;
      lin_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      pre_q  <= pre_d;
      lin_q  <= lin_d;
      sclk_q <= sclk_d;
    end
  end

  assign act_cfg = act_q;
  assign sclk    = sclk_q;
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_rate_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               sclk_en,
  input  logic               sclk_idle,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [DIV_W-1:0]   div_o,
  output logic [BRG_W-1:0]   brg_o,
  output logic [RATIO_W-1:0] min_ratio,
  output logic [RATIO_W-1:0] max_ratio,
  output logic               sclk
);
  logic [1:0] rst_pipe_q;
  logic       rst_i;
  rate_cfg_t  sol_cfg;
  rate_cfg_t  act_cfg;
  logic [DIV_W-1:0] act_div;
  logic [BRG_W-1:0] act_brg;

  // asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i = rst_pipe_q[1];

  spi_rate_solver #(.RATIO_W(RATIO_W)) i_solver (
    .clk    (clk),
    .rst_ni (rst_i),
    .start  (start),
    .ratio  (ratio),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .result (sol_cfg)
  );

  spi_sclk_gen i_gen (
    .clk      (clk),
    .rst_ni   (rst_i),
    .en       (sclk_en),
    .idle_lvl (sclk_idle),
    .cfg_in   (sol_cfg),
    .act_cfg  (act_cfg),
    .sclk     (sclk)
  );

  assign act_div   = act_cfg.div;
  assign act_brg   = act_cfg.brg;
  assign div_o     = sol_cfg.div;
  assign brg_o     = sol_cfg.brg;
  assign min_ratio = RATIO_W'(MIN_RATIO);
  assign max_ratio = RATIO_W'(MAX_RATIO);
endmodule

// File: rtl/spi_rate_gen_chk.sv
module spi_rate_gen_chk
  import spi_rate_pkg::*;
(
  input logic             clk,
  input logic             rst_ni,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [BRG_W-1:0] brg_o,
  input logic             sclk_en,
  input logic             sclk_idle,
  input logic             sclk,
  input logic [DIV_W-1:0] act_div,
  input logic [BRG_W-1:0] act_brg
);
  logic [DIV_W:0] run_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                        run_q <= '0;
    else if (!busy)                     run_q <= '0;
    else if (run_q != '1)               run_q <= run_q + 1'b1;
  end

  p_search_bound_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> (run_q < (DIV_W+1)'(DIV_HI + 1)));

  p_result_legal_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> (brg_o >= BRG_W'(BRG_LO)));

  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !(done && err));

  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !sclk_en |=> (sclk == $past(sclk_idle)));

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    sclk_en |=> ($stable(act_div) && $stable(act_brg)));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  p_busy_end_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |-> done);
endmodule

bind spi_rate_gen spi_rate_gen_chk i_chk (
  .clk       (clk),
  .rst_ni    (rst_i),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .brg_o     (brg_o),
  .sclk_en   (sclk_en),
  .sclk_idle (sclk_idle),
  .sclk      (sclk),
  .act_div   (act_div),
  .act_brg   (act_brg)
);

// File: tb/test_spi_rate_gen.sv
`timescale 1ns/1ps
module test_spi_rate_gen;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [RW-1:0] ratio;
  logic          sclk_en;
  logic          sclk_idle;
  logic          busy, done, err, sclk;
  logic [1:0]    div_o;
  logic [5:0]    brg_o;
  logic [RW-1:0] min_ratio, max_ratio;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_rate_gen #(.RATIO_W(RW)) i_spi_rate_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .ratio(ratio),
    .sclk_en(sclk_en), .sclk_idle(sclk_idle), .busy(busy), .done(done),
    .err(err), .div_o(div_o), .brg_o(brg_o), .min_ratio(min_ratio),
    .max_ratio(max_ratio), .sclk(sclk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model built from the requirement text
  task automatic model(input int r, output int d, output int b, output int lat);
    d = 3; b = 63; lat = 4;
    for (int k = 0; k < 4; k++) begin
      int q;
      q = r / (4 << k);
      if (q < 5)  begin d = k; b = 4;     lat = k + 1; return; end
      if (q <= 64) begin d = k; b = q - 1; lat = k + 1; return; end
    end
  endtask

  // one search; checks latency, fields, busy and pulse width
  task automatic t_solve(input int r);
    int ed, eb, el, got;
    model(r, ed, eb, el);
    @(negedge clk); start = 1'b1; ratio = RW'(r);
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R12 busy after start", busy, 1);
    got = 0;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (done) begin got = c; break; end
    end
    chk(got == el, "R2 latency", got, el);
    chk(div_o == 2'(ed), (r < 20) ? "R4 div" : (r >= 2080) ? "R5 div" : "R3 div", div_o, ed);
    chk(brg_o == 6'(eb), (r < 20) ? "R4 brg" : (r >= 2080) ? "R5 brg" : "R3 brg", brg_o, eb);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R12 done single pulse", done, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && err == 0, "R1 flags", {busy, done, err}, 0);
    chk(div_o == 0, "R1 div", div_o, 0);
    chk(brg_o == 4, "R1 brg", brg_o, 4);
    chk(sclk == sclk_idle, "R1 sclk idle", sclk, sclk_idle);
    chk(min_ratio == 20, "R8 min", min_ratio, 20);
    chk(max_ratio == 2048, "R8 max", max_ratio, 2048);
  endtask

  task automatic t_zero();
    logic [1:0] pd; logic [5:0] pb; bit seen;
    pd = div_o; pb = brg_o;
    @(negedge clk); start = 1'b1; ratio = '0;
    @(negedge clk); start = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R6 err pulse", err, 1);
    @(negedge clk);
    chk(err == 1'b0, "R6 err one cycle", err, 0);
    seen = 0;
    for (int c = 0; c < 6; c++) begin @(negedge clk); if (done) seen = 1; end
    chk(!seen, "R6 no done", seen, 0);
    chk(div_o == pd && brg_o == pb, "R6 fields kept", {div_o, brg_o}, {pd, pb});
  endtask

  task automatic t_busy_ignore();
    int got; bit extra;
    @(negedge clk); start = 1'b1; ratio = RW'(2080);
    @(negedge clk); ratio = RW'(100);   // still strobing while busy
    @(negedge clk); start = 1'b0;
    got = (done) ? 1 : 0;
    for (int c = 2; c <= 8 && got == 0; c++) begin
      @(negedge clk);
      if (done) got = c;
    end
    chk(got == 4, "R7 first search latency", got, 4);
    chk(div_o == 3 && brg_o == 63, "R7 first ratio kept", brg_o, 63);
    extra = 0;
    for (int c = 0; c < 8; c++) begin @(negedge clk); if (done || busy) extra = 1; end
    chk(!extra, "R7 no second search", extra, 0);
  endtask

  task automatic half_period(output int n);
    logic prev;
    prev = sclk; n = 0;
    for (int c = 1; c <= 5000; c++) begin
      @(negedge clk);
      if (sclk != prev) begin n = c; return; end
    end
  endtask

  task automatic t_clock(input int r, input logic pol);
    int ed, eb, el, h, n;
    sclk_idle = pol;
    t_solve(r);
    model(r, ed, eb, el);
    h = (2 << ed) * (eb + 1);
    @(negedge clk);
    chk(sclk == pol, "R9 idle level", sclk, pol);
    sclk_en = 1'b1;
    half_period(n);
    chk(n == h, "R10 first half period", n, h);
    half_period(n);
    chk(n == h, "R10 second half period", n, h);
    @(negedge clk); sclk_en = 1'b0;
    @(negedge clk);
    chk(sclk == pol, "R9 back to idle", sclk, pol);
  endtask

  task automatic t_hold();
    int n;
    sclk_idle = 1'b0;
    t_solve(100);
    @(negedge clk); sclk_en = 1'b1;
    t_solve(1000);             // new result while running
    half_period(n);
    half_period(n);
    chk(n == 50, "R11 rate unchanged while enabled", n, 50);
    @(negedge clk); sclk_en = 1'b0;
    @(negedge clk); sclk_en = 1'b1;
    half_period(n);
    chk(n == 496, "R11 new rate after idle", n, 496);
    @(negedge clk); sclk_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ratio = '0; sclk_en = 1'b0; sclk_idle = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_solve(100);
    t_solve(260);
    t_solve(1000);
    t_solve(2079);
    t_solve(259);
    t_solve(20);
    t_solve(19);
    t_solve(1);
    t_solve(2080);
    t_solve(65535);
    t_zero();
    t_busy_ignore();
    t_clock(100, 1'b1);
    t_clock(20, 1'b0);
    t_clock(1000, 1'b1);
    t_hold();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule